// File: doc/BRIEF.md
# Receive Label Filter

This block sits between a serial-bus receiver front end and the receive FIFO. Each time the front end delivers a complete 32-bit word, the block decides whether the word is accepted. When it accepts a word, it raises a one-cycle strobe and presents the word. When it rejects a word, nothing appears at the output.

Two checks decide acceptance, and each can be enabled on its own. The first compares the word's 8-bit label field against a 16-entry label memory. The second requires bits 9 and 10 of the word to equal two programmed values. When both checks are enabled, a word must pass both.

The host loads and reads back the label memory through a sequential access mode. Writing the access bit of the control register from 0 to 1 starts the mode. The next 16 label writes fill the entries in order, and the next 16 label reads return them in order. While the mode is active, no words are accepted. The host writes the access bit back to 0 to return to normal filtering.

Top module: `rx_label_filter`

## Requirements
- R1: After reset, `acc_vld_o` and `host_rdata_o` are 0, every control field is 0 (so both checks are off and access mode is off), and every label entry holds 0x00.
- R2: A word presented with `word_vld_i` high is accepted when it passes every enabled check and access mode is off. `acc_vld_o` is high for exactly the next cycle, and `acc_word_o` equals the input word.
- R3: When the filter-enable field (control bit 1) is set, a word passes the filter only if `word_i[7:0]` equals a stored label. Stored label bit k is compared with `word_i[k]`, so serial bits 1 to 8 map to label bits 0 to 7 in that order.
- R4: The label value 0x00 matches a word whose label field is 0x00 exactly like any other value, and it has no other meaning.
- R5: A rejected word leaves `acc_vld_o` low.
- R6: A control write with bit 0 set, when bit 0 was previously 0, starts access mode. The write and read sequence counters both restart at entry 0. Each later `host_wr_i` stores `host_wdata_i[7:0]` into the next entry, from entry 0 to entry 15.
- R7: In access mode, each `host_rd_i` returns the next entry, from entry 0 up, on `host_rdata_o[7:0]` in the following cycle. Bits 15:8 are always zero. `host_rdata_o` holds its value in cycles with no read.
- R8: While control bit 0 (access mode) is 1, no word is accepted.
- R9: When the decoder-enable field (control bit 2) is set, a word passes the decoder only if `word_i[8]` equals control bit 3 and `word_i[9]` equals control bit 4.
- R10: When both the filter and the decoder are enabled, a word is accepted only if it passes both.
- R11: After 16 writes or 16 reads in one access session, further writes leave the memory unchanged and further reads return 0. A control write that keeps bit 0 at 1 does not restart the counters. Reads made outside access mode return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_i | input | 16 | Control write data: bit0 access, bit1 filter en, bit2 decoder en, bit3/bit4 expected word bits 9/10 |
| host_wr_i | input | 1 | Label write strobe |
| host_wdata_i | input | 16 | Label write data, low 8 bits used |
| host_rd_i | input | 1 | Label read strobe |
| host_rdata_o | output | 16 | Label read data, valid the cycle after a read |
| word_vld_i | input | 1 | Received word valid |
| word_i | input | 32 | Received word, bit 0 is serial bit 1 |
| acc_vld_o | output | 1 | Accepted word strobe |
| acc_word_o | output | 32 | Accepted word |

## Verification
Every result of this block is due one clock edge after its stimulus. The accept decision for a word, the readback of a label, and a change to the control fields all come from a single register stage. The bench drives each stimulus on a falling edge, removes it at the next falling edge, and checks the outputs at that same moment. That moment falls half a cycle after the rising edge that registered the result. A word that arrives in the same cycle as a control write is filtered using the control fields from before the write. The bench therefore never applies a control change and a word together.

// File: rtl/rlf_pkg.sv
package rlf_pkg;
  // Control register field positions (host-visible encoding)
  localparam int CTRL_ACCESS = 0;
  localparam int CTRL_FILT   = 1;
  localparam int CTRL_DEC    = 2;
  localparam int CTRL_B9     = 3;
  localparam int CTRL_B10    = 4;

  typedef struct packed {
    logic b10;
    logic b9;
    logic dec_en;
    logic filt_en;
    logic access;
  } rlf_ctrl_t;
endpackage

// File: rtl/rlf_seq_ctrl.sv
module rlf_seq_ctrl
  import rlf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int BUS_W = 16,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr_i,
  input  logic [BUS_W-1:0] ctrl_i,
  input  logic             host_wr_i,
  input  logic             host_rd_i,
  output rlf_ctrl_t        ctrl_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_cnt_o,
  output logic             rd_hit_o,
  output logic [PTR_W-1:0] rd_cnt_o
);
  rlf_ctrl_t        ctrl_q, ctrl_d;
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic             start;

  always_comb begin
    start    = ctrl_wr_i && ctrl_i[CTRL_ACCESS] && !ctrl_q.access;
    wr_en_o  = host_wr_i && ctrl_q.access && (wp_q < PTR_W'(DEPTH));
    rd_hit_o = host_rd_i && ctrl_q.access && (rp_q < PTR_W'(DEPTH));

    ctrl_d = ctrl_q;
    if (ctrl_wr_i) begin
      ctrl_d.access  = ctrl_i[CTRL_ACCESS];
      ctrl_d.filt_en = ctrl_i[CTRL_FILT];
      ctrl_d.dec_en  = ctrl_i[CTRL_DEC];
      ctrl_d.b9      = ctrl_i[CTRL_B9];
      ctrl_d.b10     = ctrl_i[CTRL_B10];
    end

    wp_d = wp_q;
    rp_d = rp_q;
    if (start) begin
      wp_d = '0;
      rp_d = '0;
    end else begin
      if (wr_en_o)  wp_d = wp_q + 1'b1;
      if (rd_hit_o) rp_d = rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      wp_q   <= '0;
      rp_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      wp_q   <= wp_d;
      rp_q   <= rp_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign wr_cnt_o = wp_q;
  assign rd_cnt_o = rp_q;
endmodule

// File: rtl/rlf_label_store.sv
module rlf_label_store #(
  parameter int DEPTH = 16,
  parameter int LBL_W = 8,
  parameter int BUS_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [LBL_W-1:0] wr_lbl_i,
  input  logic             rd_any_i,
  input  logic             rd_hit_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic [LBL_W-1:0] cmp_lbl_i,
  output logic             hit_o
);
  logic [LBL_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0] match;
  logic [BUS_W-1:0] rdata_q, rdata_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic ld;
    assign ld       = wr_en_i && (wr_idx_i == IDX_W'(i));
    assign match[i] = (mem_q[i] == cmp_lbl_i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[i] <= '0;
      else if (ld) mem_q[i] <= wr_lbl_i;
    end
  end

  always_comb begin
    rdata_d = '0;
    if (rd_hit_i) rdata_d[LBL_W-1:0] = mem_q[rd_idx_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rd_any_i) rdata_q <= rdata_d;
  end

  assign hit_o   = |match;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/rlf_word_gate.sv
module rlf_word_gate
  import rlf_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LBL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rlf_ctrl_t         ctrl_i,
  input  logic              hit_i,
  input  logic              vld_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              acc_vld_o,
  output logic [WORD_W-1:0] acc_word_o
);
  logic              pass_filt, pass_dec, take;
  logic              vld_q;
  logic [WORD_W-1:0] word_q;

  always_comb begin
    pass_filt = !ctrl_i.filt_en || hit_i;
    pass_dec  = !ctrl_i.dec_en ||
                ((word_i[LBL_W] == ctrl_i.b9) && (word_i[LBL_W+1] == ctrl_i.b10));
    take      = vld_i && !ctrl_i.access && pass_filt && pass_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (take) word_q <= word_i;
  end

  assign acc_vld_o  = vld_q;
  assign acc_word_o = word_q;
endmodule

// File: rtl/rx_label_filter.sv
module rx_label_filter
  import rlf_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LBL_W  = 8,
  parameter int DEPTH  = 16,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr_i,
  input  logic [BUS_W-1:0]  ctrl_i,
  input  logic              host_wr_i,
  input  logic [BUS_W-1:0]  host_wdata_i,
  input  logic              host_rd_i,
  output logic [BUS_W-1:0]  host_rdata_o,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              acc_vld_o,
  output logic [WORD_W-1:0] acc_word_o
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  rlf_ctrl_t        ctrl_s;
  logic             wr_en, rd_hit, hit;
  logic [PTR_W-1:0] wr_cnt, rd_cnt;

  rlf_seq_ctrl #(.DEPTH(DEPTH), .BUS_W(BUS_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr_i(ctrl_wr_i),
    .ctrl_i   (ctrl_i),
    .host_wr_i(host_wr_i),
    .host_rd_i(host_rd_i),
    .ctrl_o   (ctrl_s),
    .wr_en_o  (wr_en),
    .wr_cnt_o (wr_cnt),
    .rd_hit_o (rd_hit),
    .rd_cnt_o (rd_cnt)
  );

  rlf_label_store #(.DEPTH(DEPTH), .LBL_W(LBL_W), .BUS_W(BUS_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_cnt[IDX_W-1:0]),
    .wr_lbl_i (host_wdata_i[LBL_W-1:0]),
    .rd_any_i (host_rd_i),
    .rd_hit_i (rd_hit),
    .rd_idx_i (rd_cnt[IDX_W-1:0]),
    .rdata_o  (host_rdata_o),
    .cmp_lbl_i(word_i[LBL_W-1:0]),
    .hit_o    (hit)
  );

  rlf_word_gate #(.WORD_W(WORD_W), .LBL_W(LBL_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_i    (ctrl_s),
    .hit_i     (hit),
    .vld_i     (word_vld_i),
    .word_i    (word_i),
    .acc_vld_o (acc_vld_o),
    .acc_word_o(acc_word_o)
  );
endmodule

// File: rtl/rlf_checker.sv
module rlf_checker #(
  parameter int WORD_W = 32,
  parameter int LBL_W  = 8,
  parameter int DEPTH  = 16,
  parameter int BUS_W  = 16,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_vld_i,
  input logic [WORD_W-1:0] word_i,
  input logic              acc_vld_o,
  input logic [WORD_W-1:0] acc_word_o,
  input logic              host_rd_i,
  input logic [BUS_W-1:0]  host_rdata_o,
  input logic              access,
  input logic              dec_en,
  input logic              dec_b9,
  input logic              dec_b10,
  input logic [PTR_W-1:0]  wr_cnt
);
  a_r2_vld_origin: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld_o |-> $past(word_vld_i));

  a_r2_word_copy: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld_o |-> (acc_word_o == $past(word_i)));

  a_r8_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    $past(access) |-> !acc_vld_o);

  a_r9_dec_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld_o && $past(dec_en)) |->
      (acc_word_o[LBL_W] == $past(dec_b9)) && (acc_word_o[LBL_W+1] == $past(dec_b10)));

  a_r11_ptr_sat: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt <= PTR_W'(DEPTH));

  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(host_rd_i) |-> $stable(host_rdata_o));

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata_o[BUS_W-1:LBL_W] == '0);
endmodule

bind rx_label_filter rlf_checker #(
  .WORD_W(WORD_W), .LBL_W(LBL_W), .DEPTH(DEPTH), .BUS_W(BUS_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .word_vld_i  (word_vld_i),
  .word_i      (word_i),
  .acc_vld_o   (acc_vld_o),
  .acc_word_o  (acc_word_o),
  .host_rd_i   (host_rd_i),
  .host_rdata_o(host_rdata_o),
  .access      (ctrl_s.access),
  .dec_en      (ctrl_s.dec_en),
  .dec_b9      (ctrl_s.b9),
  .dec_b10     (ctrl_s.b10),
  .wr_cnt      (wr_cnt)
);

// File: tb/rx_label_filter_tb_top.sv
module rx_label_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_wr_i, host_wr_i, host_rd_i, word_vld_i;
  logic [15:0] ctrl_i, host_wdata_i, host_rdata_o;
  logic [31:0] word_i, acc_word_o;
  logic        acc_vld_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // model state
  logic [7:0] m_mem [16];
  bit m_access, m_filt, m_dec, m_b9, m_b10;
  int m_wp, m_rp;

  always #2 clk = ~clk;

  rx_label_filter dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr_i), .ctrl_i(ctrl_i),
    .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i), .host_rd_i(host_rd_i),
    .host_rdata_o(host_rdata_o), .word_vld_i(word_vld_i), .word_i(word_i),
    .acc_vld_o(acc_vld_o), .acc_word_o(acc_word_o)
  );

  function automatic bit in_table(logic [7:0] l);
    for (int i = 0; i < 16; i++) if (m_mem[i] == l) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit exp_acc(logic [31:0] w);
    bit f_ok, d_ok;
    f_ok = !m_filt || in_table(w[7:0]);
    d_ok = !m_dec || ((w[8] == m_b9) && (w[9] == m_b10));
    return !m_access && f_ok && d_ok;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ctrl_write(logic [15:0] v);
    @(negedge clk);
    ctrl_wr_i = 1'b1; ctrl_i = v;
    @(negedge clk);
    ctrl_wr_i = 1'b0;
    if (v[0] && !m_access) begin m_wp = 0; m_rp = 0; end
    m_access = v[0]; m_filt = v[1]; m_dec = v[2]; m_b9 = v[3]; m_b10 = v[4];
  endtask

  task automatic lbl_write(logic [7:0] v);
    @(negedge clk);
    host_wr_i = 1'b1; host_wdata_i = {8'hA5, v};
    @(negedge clk);
    host_wr_i = 1'b0;
    if (m_access && m_wp < 16) begin m_mem[m_wp] = v; m_wp++; end
  endtask

  task automatic lbl_read(string req);
    logic [15:0] e;
    e = 16'h0;
    if (m_access && m_rp < 16) begin e = {8'h0, m_mem[m_rp]}; m_rp++; end
    @(negedge clk);
    host_rd_i = 1'b1;
    @(negedge clk);
    host_rd_i = 1'b0;
    chk(host_rdata_o == e, req, {16'h0, host_rdata_o}, {16'h0, e});
  endtask

  task automatic send_word(logic [31:0] w, string req);
    bit e;
    e = exp_acc(w);
    @(negedge clk);
    word_vld_i = 1'b1; word_i = w;
    @(negedge clk);
    word_vld_i = 1'b0;
    chk(acc_vld_o == e, req, {31'h0, acc_vld_o}, {31'h0, e});
    if (e) chk(acc_word_o == w, req, acc_word_o, w);
  endtask

  function automatic logic [7:0] tbl_lbl(int i);
    return 8'((i * 37 + 1) & 8'hFF);
  endfunction

  function automatic logic [31:0] rnd_word(bit from_tbl);
    logic [31:0] w;
    w = $urandom;
    if (from_tbl) w[7:0] = m_mem[$urandom % 16];
    return w;
  endfunction

  initial begin
    int dummy;
    dummy = $urandom(32'd2024);
    rst_n = 1'b0; ctrl_wr_i = 0; ctrl_i = 0; host_wr_i = 0; host_wdata_i = 0;
    host_rd_i = 0; word_vld_i = 0; word_i = 0;
    m_access = 0; m_filt = 0; m_dec = 0; m_b9 = 0; m_b10 = 0; m_wp = 0; m_rp = 0;
    for (int i = 0; i < 16; i++) m_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(acc_vld_o == 1'b0, "R1", {31'h0, acc_vld_o}, 32'h0);
    chk(host_rdata_o == 16'h0, "R1", {16'h0, host_rdata_o}, 32'h0);
    send_word(32'hDEADBEEF, "R1");
    // R2 pass-through with checks off
    for (int i = 0; i < 8; i++) send_word($urandom, "R2");
    // R11 read outside access mode
    lbl_read("R11");
    // R6 load labels in access mode; R8 suspension
    ctrl_write(16'h0001);
    send_word(32'h0000_0001, "R8");
    for (int i = 0; i < 16; i++) lbl_write(tbl_lbl(i));
    send_word(32'h0000_0026, "R8");
    lbl_write(8'hEE); // R11 extra write ignored
    for (int i = 0; i < 16; i++) lbl_read("R6 R7");
    lbl_read("R11");
    ctrl_write(16'h0001); // R11 no restart without 0-to-1
    lbl_read("R11");
    ctrl_write(16'h0000);
    // R3/R5 filter
    ctrl_write(16'h0002);
    send_word(32'h0000_0001, "R3");
    send_word(32'h0000_0080, "R3"); // reversed bit order not stored
    send_word(32'h0000_0000, "R4"); // 0x00 not stored -> reject
    for (int i = 0; i < 24; i++) send_word(rnd_word(i % 2 == 0), "R3 R5");
    // R4 store 0x00 as a label
    ctrl_write(16'h0003);
    for (int i = 0; i < 15; i++) lbl_write(tbl_lbl(i));
    lbl_write(8'h00);
    ctrl_write(16'h0002);
    send_word(32'h1234_5600, "R4");
    send_word(32'h1234_5680, "R4");
    // R9 decoder alone
    for (int k = 0; k < 4; k++) begin
      ctrl_write(16'(16'h0004 | (k << 3)));
      for (int i = 0; i < 6; i++) send_word($urandom, "R9");
    end
    // R10 both checks
    ctrl_write(16'h0016); // filt, dec, b9=0, b10=1
    send_word(32'h0000_0201, "R10");
    send_word(32'h0000_0101, "R10");
    send_word(32'h0000_0280, "R10");
    for (int i = 0; i < 20; i++) send_word(rnd_word(i % 2 == 0), "R10");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule